// File: doc/BRIEF.md
# Multicast Spike-Event Router

This block routes small event packets inside one node of a large message-passing array. It has six inputs from neighbouring nodes and one input from local cores. Packets from these seven sources are merged into a single stream. At most one packet is taken per clock. Each packet names the neuron that fired through a 32-bit source identifier. A table of masked keys turns that identifier into a 24-bit set of destinations: six inter-node links and eighteen local cores. The packet is then copied to every destination in the set.

The router never holds a sender back for long because an output is busy. A copy that a link does not take within a programmable time is moved to the next link clockwise, and the packet is marked so that it is never moved a second time. A copy that is still not taken after a second programmable time is abandoned. Two saturating counters record how many packets were diverted and how many were dropped. Table entries are loaded through a simple write port.

A packet is 72 bits, packed as {ctrl[7:0], id[31:0], payload[31:0]}. Bit 7 of ctrl is the diverted mark. Every other bit, including a payload-present flag that software may keep in ctrl, is carried through unchanged.

Top module: `spike_router`

## Requirements
- R1: A table entry matches when (id & mask) == key. The lowest-numbered matching entry gives the route vector. In that vector, bits 0..5 select links 0..5 and bits 6..23 select cores 0..17. The packet is offered on out_pkt_o with out_valid_o equal to that vector.
- R2: When no entry matches, a packet from link source s (0..5) goes to link (s+3) mod 6. A packet from the local source (index 6) that matches no entry is dropped, and the drop counter goes up by one in the cycle after it is accepted.
- R3: Sources 0..5 are the links and source 6 is the local cores. At most one in_ready_o bit is high in any cycle. Grants go round-robin, starting at source 0 after reset.
- R4: A packet accepted at a clock edge is visible on out_valid_o in the next cycle. If every selected output is ready in that cycle, the stage empties at the next edge, and a new packet is accepted at that same edge.
- R5: Count cycle k=0 as the first cycle a packet is offered. If a link copy is still not taken in cycle k=D, where D = cfg_divert_wait_i, then from cycle D+1 that copy is offered on link (i+1) mod 6 instead. From then on, ctrl bit 7 of out_pkt_o reads 1, and divert_cnt_o has gone up by one.
- R6: A packet that arrives with ctrl bit 7 set is never diverted. Its blocked copies stay on their original ports, and divert_cnt_o does not change.
- R7: If any copy is still not taken in cycle D+1+P, where P = cfg_drop_wait_i, every remaining copy is abandoned. out_valid_o reads 0 from the next cycle, and drop_cnt_o has gone up by one.
- R8: drop_cnt_o and divert_cnt_o are 16 bits wide and hold at 0xFFFF once they reach it.
- R9: The id, the payload and ctrl bits 6..0 leave the router unchanged.
- R10: After reset, no table entry matches, out_valid_o is 0 and both counters are 0. An entry whose route vector is 0 takes in a matching packet silently, without counting a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 7 | Packet offered per source (0..5 links, 6 local) |
| in_pkt_i | input | 504 | Packets per source, source s at bits [72s+71:72s] |
| in_ready_o | output | 7 | Packet taken from that source at this edge |
| out_valid_o | output | 24 | Copy pending per output (0..5 links, 6..23 cores) |
| out_ready_i | input | 24 | Output can take the copy |
| out_pkt_o | output | 72 | Packet shared by all pending outputs |
| tbl_wr_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 6 | Entry index |
| tbl_key_i | input | 32 | Key to store |
| tbl_mask_i | input | 32 | Mask to store |
| tbl_route_i | input | 24 | Route vector to store |
| cfg_divert_wait_i | input | 8 | Cycles before a blocked link copy is diverted |
| cfg_drop_wait_i | input | 8 | Further cycles before remaining copies are dropped |
| drop_cnt_o | output | 16 | Saturating count of dropped packets |
| divert_cnt_o | output | 16 | Saturating count of diverted packets |

## Verification
Suppose the pending vector kept a bit after that output accepted its copy. The same copy would then go out twice, and both the next in_ready_o and later packets would be held up. A test sees this in the cycle after the handshake. Suppose the wait counter or the phase went wrong. The clockwise copy, the diverted mark or the counter step would then appear a cycle early or late, against the cycle numbers fixed by R5 and R7. A wrong round-robin pointer shows up as the wrong in_ready_o bit in the very next cycle in which two sources both offer a packet.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int PKT_W    = 72;
  localparam int ID_W     = 32;
  localparam int CTRL_LSB = 64;
  localparam int ID_LSB   = 32;
  localparam int MARK_BIT = CTRL_LSB + 7;  // diverted mark in ctrl byte
endpackage

// File: rtl/rtr_merge.sv
module rtr_merge #(
  parameter int N_SRC = 7,
  parameter int PKT_W = 72
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SRC-1:0]         valid_i,
  input  logic [N_SRC*PKT_W-1:0]   pkt_i,
  input  logic                     take_i,
  output logic [N_SRC-1:0]         ready_o,
  output logic                     sel_valid_o,
  output logic [$clog2(N_SRC)-1:0] sel_src_o,
  output logic [PKT_W-1:0]         sel_pkt_o
);
  localparam int SRC_W = $clog2(N_SRC);

  logic [SRC_W-1:0] ptr_q, gidx;
  logic             found;
  int               kk;

  always_comb begin
    found = 1'b0;
    gidx  = '0;
    kk    = 0;
    for (int j = 0; j < N_SRC; j++) begin
      kk = int'(ptr_q) + j;
      if (kk >= N_SRC) kk = kk - N_SRC;
      if (!found && valid_i[kk]) begin
        found = 1'b1;
        gidx  = SRC_W'(kk);
      end
    end
  end

  assign sel_valid_o = found;
  assign sel_src_o   = gidx;
  assign sel_pkt_o   = pkt_i[int'(gidx)*PKT_W +: PKT_W];

  always_comb begin
    ready_o = '0;
    if (found && take_i) ready_o[gidx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found && take_i)
      ptr_q <= (int'(gidx) == N_SRC-1) ? '0 : gidx + 1'b1;
  end

  // R3: a single source is granted per cycle
  p_single_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ready_o));

  // R3: a granted source was offering a packet
  p_grant_has_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~valid_i) == '0);
endmodule

// File: rtl/rtr_table.sv
module rtr_table #(
  parameter int N_ENT = 64,
  parameter int ID_W  = 32,
  parameter int N_OUT = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [$clog2(N_ENT)-1:0] addr_i,
  input  logic [ID_W-1:0]          key_i,
  input  logic [ID_W-1:0]          mask_i,
  input  logic [N_OUT-1:0]         route_i,
  input  logic [ID_W-1:0]          id_i,
  output logic                     hit_o,
  output logic [N_OUT-1:0]         vec_o
);
  logic [ID_W-1:0]  key_q  [N_ENT];
  logic [ID_W-1:0]  mask_q [N_ENT];
  logic [N_OUT-1:0] vec_q  [N_ENT];

  // reset value key=ones, mask=0 can never match
  generate
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          key_q[e]  <= '1;
          mask_q[e] <= '0;
          vec_q[e]  <= '0;
        end else if (wr_i && int'(addr_i) == e) begin
          key_q[e]  <= key_i;
          mask_q[e] <= mask_i;
          vec_q[e]  <= route_i;
        end
      end
    end
  endgenerate

  // scan downward so the lowest index wins
  always_comb begin
    hit_o = 1'b0;
    vec_o = '0;
    for (int i = N_ENT-1; i >= 0; i--) begin
      if ((id_i & mask_q[i]) == key_q[i]) begin
        hit_o = 1'b1;
        vec_o = vec_q[i];
      end
    end
  end
endmodule

// File: rtl/rtr_emit.sv
module rtr_emit #(
  parameter int N_LINKS = 6,
  parameter int N_OUT   = 24,
  parameter int PKT_W   = 72,
  parameter int WAIT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N_OUT-1:0]  load_vec_i,
  input  logic [PKT_W-1:0]  load_pkt_i,
  input  logic [N_OUT-1:0]  out_ready_i,
  input  logic [WAIT_W-1:0] div_wait_i,
  input  logic [WAIT_W-1:0] drop_wait_i,
  output logic [N_OUT-1:0]  out_valid_o,
  output logic [PKT_W-1:0]  out_pkt_o,
  output logic              free_o,
  output logic              div_evt_o,
  output logic              drop_evt_o
);
  import rtr_pkg::*;

  logic [N_OUT-1:0]   pend_q, remain;
  logic [PKT_W-1:0]   pkt_q;
  logic               phase_q;  // 0: before divert point, 1: before drop point
  logic [WAIT_W-1:0]  wcnt_q;
  logic [N_LINKS-1:0] rem_links, rot_links;
  logic               div_point;

  assign remain     = pend_q & ~out_ready_i;
  assign rem_links  = remain[N_LINKS-1:0];
  assign rot_links  = {rem_links[N_LINKS-2:0], rem_links[N_LINKS-1]};
  assign div_point  = !phase_q && (wcnt_q == div_wait_i) && (remain != '0);
  assign div_evt_o  = div_point && (rem_links != '0) && !pkt_q[MARK_BIT];
  assign drop_evt_o = phase_q && (wcnt_q == drop_wait_i) && (remain != '0);
  assign free_o     = (remain == '0) || drop_evt_o;

  assign out_valid_o = pend_q;
  assign out_pkt_o   = pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      pkt_q   <= '0;
      phase_q <= 1'b0;
      wcnt_q  <= '0;
    end else if (load_i) begin
      pend_q  <= load_vec_i;
      pkt_q   <= load_pkt_i;
      phase_q <= 1'b0;
      wcnt_q  <= '0;
    end else if (drop_evt_o) begin
      pend_q <= '0;
    end else if (div_point) begin
      phase_q <= 1'b1;
      wcnt_q  <= '0;
      if (div_evt_o) begin
        pend_q <= {remain[N_OUT-1:N_LINKS], rot_links};
        pkt_q[MARK_BIT] <= 1'b1;
      end else begin
        pend_q <= remain;
      end
    end else begin
      pend_q <= remain;
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  // R4: all selected outputs ready empties the stage at the next edge
  p_fire_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0 && remain == '0 && !load_i) |=> (pend_q == '0));

  // R6: a marked packet never gains an output
  p_marked_no_new_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0 && pkt_q[MARK_BIT] && !load_i) |=> ((pend_q & ~$past(pend_q)) == '0));

  // R5: a diverted packet carries the mark next cycle
  p_div_marks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_evt_o && !load_i) |=> out_pkt_o[MARK_BIT]);

  // R7: after a drop nothing stays pending unless a new packet loads
  p_drop_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_evt_o && !load_i) |=> (out_valid_o == '0));
endmodule

// File: rtl/rtr_sat_cnt.sv
module rtr_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + {{(CNT_W-1){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (sum[CNT_W]) cnt_o <= '1;
    else cnt_o <= sum[CNT_W-1:0];
  end

  // R8: full scale holds
  p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '1) |=> (cnt_o == '1));
endmodule

// File: rtl/spike_router.sv
module spike_router #(
  parameter int N_LINKS = 6,
  parameter int N_CORES = 18,
  parameter int N_ENT   = 64,
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = 16,
  localparam int N_SRC  = N_LINKS + 1,
  localparam int N_OUT  = N_LINKS + N_CORES,
  localparam int AW     = $clog2(N_ENT),
  localparam int PW     = rtr_pkg::PKT_W,
  localparam int IW     = rtr_pkg::ID_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    in_valid_i,
  input  logic [N_SRC*PW-1:0] in_pkt_i,
  output logic [N_SRC-1:0]    in_ready_o,
  output logic [N_OUT-1:0]    out_valid_o,
  input  logic [N_OUT-1:0]    out_ready_i,
  output logic [PW-1:0]       out_pkt_o,
  input  logic                tbl_wr_i,
  input  logic [AW-1:0]       tbl_addr_i,
  input  logic [IW-1:0]       tbl_key_i,
  input  logic [IW-1:0]       tbl_mask_i,
  input  logic [N_OUT-1:0]    tbl_route_i,
  input  logic [WAIT_W-1:0]   cfg_divert_wait_i,
  input  logic [WAIT_W-1:0]   cfg_drop_wait_i,
  output logic [CNT_W-1:0]    drop_cnt_o,
  output logic [CNT_W-1:0]    divert_cnt_o
);
  import rtr_pkg::*;
  localparam int SRC_W = $clog2(N_SRC);

  logic             sel_valid, free, hit, accept, is_local, miss_drop, load;
  logic             div_evt, drop_evt;
  logic [SRC_W-1:0] sel_src;
  logic [PW-1:0]    sel_pkt;
  logic [N_OUT-1:0] tbl_vec, dflt_vec, route;
  int               opp;

  rtr_merge #(.N_SRC(N_SRC), .PKT_W(PW)) u_merge (
    .clk_i, .rst_ni,
    .valid_i    (in_valid_i),
    .pkt_i      (in_pkt_i),
    .take_i     (free),
    .ready_o    (in_ready_o),
    .sel_valid_o(sel_valid),
    .sel_src_o  (sel_src),
    .sel_pkt_o  (sel_pkt)
  );

  rtr_table #(.N_ENT(N_ENT), .ID_W(IW), .N_OUT(N_OUT)) u_table (
    .clk_i, .rst_ni,
    .wr_i   (tbl_wr_i),
    .addr_i (tbl_addr_i),
    .key_i  (tbl_key_i),
    .mask_i (tbl_mask_i),
    .route_i(tbl_route_i),
    .id_i   (sel_pkt[ID_LSB +: IW]),
    .hit_o  (hit),
    .vec_o  (tbl_vec)
  );

  // miss from a link: straight across to the opposite link
  always_comb begin
    dflt_vec = '0;
    opp      = int'(sel_src) + N_LINKS/2;
    if (opp >= N_LINKS) opp = opp - N_LINKS;
    if (int'(sel_src) < N_LINKS) dflt_vec[opp] = 1'b1;
  end

  assign is_local  = (int'(sel_src) == N_LINKS);
  assign accept    = sel_valid && free;
  assign route     = hit ? tbl_vec : dflt_vec;
  assign miss_drop = accept && !hit && is_local;
  assign load      = accept && (route != '0);

  rtr_emit #(.N_LINKS(N_LINKS), .N_OUT(N_OUT), .PKT_W(PW), .WAIT_W(WAIT_W)) u_emit (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_vec_i (route),
    .load_pkt_i (sel_pkt),
    .out_ready_i,
    .div_wait_i (cfg_divert_wait_i),
    .drop_wait_i(cfg_drop_wait_i),
    .out_valid_o,
    .out_pkt_o,
    .free_o     (free),
    .div_evt_o  (div_evt),
    .drop_evt_o (drop_evt)
  );

  rtr_sat_cnt #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk_i, .rst_ni,
    .inc_i({1'b0, miss_drop} + {1'b0, drop_evt}),
    .cnt_o(drop_cnt_o)
  );

  rtr_sat_cnt #(.CNT_W(CNT_W)) u_div_cnt (
    .clk_i, .rst_ni,
    .inc_i({1'b0, div_evt}),
    .cnt_o(divert_cnt_o)
  );

  // R2: an unmatched local packet never reaches an output
  p_local_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_drop && out_valid_o == '0) |=> (out_valid_o == '0));
endmodule

// File: tb/sim_spike_router.sv
module sim_spike_router;
  localparam int NS = 7;
  localparam int NO = 24;
  localparam int PW = 72;
  localparam int NV = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   in_valid = '0;
  logic [NS*PW-1:0] in_pkt = '0;
  logic [NS-1:0]   in_ready;
  logic [NO-1:0]   out_valid, oready = '1;
  logic [PW-1:0]   out_pkt;
  logic            twr = 1'b0;
  logic [5:0]      taddr = '0;
  logic [31:0]     tkey = '0, tmask = '0;
  logic [23:0]     troute = '0;
  logic [15:0]     drop_cnt, div_cnt;
  int              n_chk = 0, n_bad = 0;
  logic            done = 1'b0;

  always #2.5 clk = ~clk;

  spike_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_pkt_i(in_pkt), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(oready), .out_pkt_o(out_pkt),
    .tbl_wr_i(twr), .tbl_addr_i(taddr), .tbl_key_i(tkey), .tbl_mask_i(tmask),
    .tbl_route_i(troute),
    .cfg_divert_wait_i(8'd3), .cfg_drop_wait_i(8'd4),
    .drop_cnt_o(drop_cnt), .divert_cnt_o(div_cnt)
  );

  // vectors: source, id, expected out_valid at k=0, expected drop count after
  localparam int          V_SRC [NV] = '{6, 0, 3, 6, 0, 4, 2, 5, 6, 1};
  localparam logic [31:0] V_ID  [NV] = '{32'h0000_1023, 32'h0000_1234, 32'h0002_0001,
                                         32'hABCD_0007, 32'h7777_0000, 32'h7777_0001,
                                         32'h9999_0000, 32'h1234_5678, 32'h7777_0000,
                                         32'h0003_0005};
  localparam logic [23:0] V_EXP [NV] = '{24'h000042, 24'h800000, 24'h00003F, 24'hFFFFFF,
                                         24'h000008, 24'h000002, 24'h000020, 24'h000004,
                                         24'h000000, 24'h000000};
  localparam int          V_DRP [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 2, 2};

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_ent(input int a, input logic [31:0] k, input logic [31:0] m,
                        input logic [23:0] r);
    @(negedge clk);
    twr = 1'b1; taddr = 6'(a); tkey = k; tmask = m; troute = r;
    @(negedge clk);
    twr = 1'b0;
  endtask

  // returns just after the accepting edge
  task automatic send(input int src, input logic [71:0] p);
    @(negedge clk);
    in_pkt[src*PW +: PW] = p;
    in_valid[src] = 1'b1;
    #0.5;
    while (!in_ready[src]) begin
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    #0.5;
    in_valid[src] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid after reset", 72'(out_valid), 72'h0);
    chk("R10 drop count after reset", 72'(drop_cnt), 72'h0);
    chk("R10 divert count after reset", 72'(div_cnt), 72'h0);
    chk("R3 no ready without valid", 72'(in_ready), 72'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: empty table, local packet dropped even for id all ones
    send(6, {8'h00, 32'hFFFF_FFFF, 32'h0});
    @(negedge clk);
    chk("R10 empty table no output", 72'(out_valid), 72'h0);
    chk("R10 R2 empty table drop", 72'(drop_cnt), 72'd1);

    wr_ent(0, 32'h0000_1000, 32'hFFFF_FF00, 24'h000042);
    wr_ent(1, 32'h0000_1000, 32'hFFFF_F000, 24'h800000);
    wr_ent(2, 32'h0002_0000, 32'hFFFF_0000, 24'h00003F);
    wr_ent(3, 32'h0003_0000, 32'hFFFF_0000, 24'h000000);
    wr_ent(5, 32'hABCD_0000, 32'hFFFF_0000, 24'hFFFFFF);
    wr_ent(10, 32'h0005_0000, 32'hFFFF_0000, 24'h000004);

    // R1 R2 R9 R10 table walk
    for (int v = 0; v < NV; v++) begin
      logic [71:0] p;
      p = {8'(8'h12 + v), V_ID[v], 32'(32'hC0DE_0000 + v)};
      send(V_SRC[v], p);
      @(negedge clk);
      chk($sformatf("R1 R2 route vec %0d", v), 72'(out_valid), 72'(V_EXP[v]));
      if (V_EXP[v] != '0) chk($sformatf("R9 content vec %0d", v), out_pkt, p);
      chk($sformatf("R2 R10 drop count vec %0d", v), 72'(drop_cnt), 72'(V_DRP[v]));
    end

    // R3 R4: two sources together, round-robin and back-to-back
    @(negedge clk);
    in_pkt[0*PW +: PW] = {8'h01, 32'hABCD_0001, 32'h1};
    in_pkt[1*PW +: PW] = {8'h02, 32'hABCD_0002, 32'h2};
    in_valid[1:0] = 2'b11;
    #0.5;
    chk("R3 grant source 0 first", 72'(in_ready), 72'h01);
    @(negedge clk);
    chk("R3 R4 grant source 1 next cycle", 72'(in_ready), 72'h02);
    chk("R4 first packet offered", out_pkt, {8'h01, 32'hABCD_0001, 32'h1});
    @(posedge clk);
    #0.5;
    in_valid = '0;
    @(negedge clk);
    chk("R4 second packet offered", out_pkt, {8'h02, 32'hABCD_0002, 32'h2});
    @(negedge clk);
    chk("R4 stage empty", 72'(out_valid), 72'h0);

    // R5: link 2 blocked, divert to link 3
    oready[2] = 1'b0;
    send(0, {8'h05, 32'h0005_0001, 32'h55});
    @(negedge clk);
    chk("R5 k0 on link 2", 72'(out_valid), 72'h04);
    repeat (3) @(negedge clk);
    chk("R5 k3 still link 2", 72'(out_valid), 72'h04);
    chk("R5 k3 no divert yet", 72'(div_cnt), 72'd0);
    @(negedge clk);
    chk("R5 k4 moved to link 3", 72'(out_valid), 72'h08);
    chk("R5 mark set", 72'(out_pkt[71]), 72'h1);
    chk("R9 R5 other ctrl bits kept", 72'(out_pkt[70:0]), 72'({7'h05, 32'h0005_0001, 32'h55}));
    chk("R5 divert count", 72'(div_cnt), 72'd1);
    @(negedge clk);
    chk("R5 diverted copy taken", 72'(out_valid), 72'h0);

    // R7: links 2 and 3 blocked, divert then drop
    oready[3] = 1'b0;
    send(0, {8'h06, 32'h0005_0002, 32'h66});
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 k4 on link 3", 72'(out_valid), 72'h08);
    chk("R7 divert count", 72'(div_cnt), 72'd2);
    repeat (4) @(negedge clk);
    chk("R7 k8 still pending", 72'(out_valid), 72'h08);
    chk("R7 k8 no drop yet", 72'(drop_cnt), 72'd2);
    @(negedge clk);
    chk("R7 k9 abandoned", 72'(out_valid), 72'h0);
    chk("R7 drop count", 72'(drop_cnt), 72'd3);

    // R6: marked packet, link 2 blocked, never diverted
    oready[3] = 1'b1;
    send(0, {8'h80, 32'h0005_0003, 32'h77});
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6 k4 stays on link 2", 72'(out_valid), 72'h04);
    chk("R6 divert count unchanged", 72'(div_cnt), 72'd2);
    repeat (5) @(negedge clk);
    chk("R6 R7 k9 dropped", 72'(out_valid), 72'h0);
    chk("R6 R7 drop count", 72'(drop_cnt), 72'd4);
    oready = '1;

    // R8: continuous local misses saturate the drop counter
    @(negedge clk);
    in_pkt[6*PW +: PW] = {8'h00, 32'h7777_0000, 32'h0};
    in_valid[6] = 1'b1;
    repeat (65540) @(negedge clk);
    in_valid[6] = 1'b0;
    @(negedge clk);
    chk("R8 drop saturated", 72'(drop_cnt), 72'hFFFF);
    repeat (3) @(negedge clk);
    chk("R8 drop holds", 72'(drop_cnt), 72'hFFFF);
    chk("R8 divert unaffected", 72'(div_cnt), 72'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule